// File: doc/BRIEF.md
# Page-Mode Read Buffer

This block sits between a synchronous read port and a slow memory array. On a read of an address whose page is not held, it asks the array for the whole page of four words, waits a fixed number of cycles, and stores the page in a small buffer. While the upper address bits stay the same, a change of the two lowest address bits only selects another word of the stored page. That word appears on the next cycle and the array is not accessed again.

The port follows a chip-enable, output-enable and write-enable convention, all active low and already sampled into the clock domain. The data output carries a drive-enable flag that a pad ring uses to control a tri-state buffer. When output enable is deasserted, the bus is released in the same cycle. When chip enable is deasserted, the block goes to standby, releases the bus and discards the stored page.

Top module: `page_read_buffer`

## Requirements
- R1: A page holds four words. The array returns them packed with word i in bits [16*i+15:16*i]. Once a page is held, `dout` shows word `addr[1:0]` of the page selected by `addr[ADDR_W-1:2]`.
- R2: A read is active only when `ce_n`=0, `oe_n`=0 and `we_n`=1. With `we_n`=0, `dout_en` stays 0 and no `arr_req` is issued.
- R3: While `oe_n`=1, `dout_en` is 0 and `dout` is 0 in the same cycle. When `oe_n` returns to 0 on a held page, the data is back one edge later and no `arr_req` is issued.
- R4: While `ce_n`=1, `dout_en` is 0 in the same cycle and the buffer is invalidated. The next read of the same page makes a full new fetch.
- R5: Suppose a read is active and the upper address bits differ from the held page, or no page is held. After the next edge, `arr_req` is 1 for that cycle and `arr_page` equals the new upper bits. `dout_en` stays 0 after that edge and after the following FETCH_LAT edges. It becomes 1 with valid data after the edge FETCH_LAT+1 edges after the request edge.
- R6: A change of only `addr[1:0]` on a held page gives the new word after the next edge, with `dout_en`=1 and no `arr_req`.
- R7: If the upper address bits change during a fetch, a new `arr_req` with the new page is issued after the next edge. The timing of R5 restarts from that edge, and the data of the new page is returned.
- R8: During a fetch, `arr_page` stays stable until the page is captured or a new request replaces it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a read needs it high |
| addr | input | ADDR_W | Word address; low two bits select the word within the page |
| arr_req | output | 1 | One-cycle request for a page fetch |
| arr_page | output | ADDR_W-2 | Page address presented to the array |
| arr_rdata | input | 4*DATA_W | Whole page from the array, valid FETCH_LAT cycles after the request |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Drive enable for the tri-state data bus |

## Verification
A miss on the upper address bits shows `arr_req` after the first edge. `dout_en` then reads 0 after each of the next FETCH_LAT edges and 1 with the right word after edge FETCH_LAT+1. An in-page change is due after one edge, and the release of the bus by `oe_n` or `ce_n` is due in the same cycle. Inputs are driven on the falling edge and outputs sampled on the following falling edge, so each check falls at a known count of rising edges after its stimulus. The expected words come from a packing formula of page and offset that the bench array model uses.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;
   typedef enum logic [1:0] {
      PG_IDLE  = 2'd0,
      PG_FETCH = 2'd1,
      PG_READY = 2'd2
   } pg_state_e;
endpackage

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl
   import pgrd_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int PAGE_WORDS = 4,
   parameter int FETCH_LAT  = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   ce_n,
   input  logic                                   rd_act,
   input  logic [ADDR_W-$clog2(PAGE_WORDS)-1:0]   addr_hi,
   output logic                                   arr_req,
   output logic [ADDR_W-$clog2(PAGE_WORDS)-1:0]   tag_q,
   output logic                                   cap_en,
   output logic                                   hit
);
   localparam int SEL_W = $clog2(PAGE_WORDS);
   localparam int HI_W  = ADDR_W - SEL_W;
   localparam int CNT_W = $clog2(FETCH_LAT + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FETCH_LAT - 1);

   pg_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pg_valid_q;
   logic             start_fetch;
   logic             tag_match;

   initial begin
      assert (FETCH_LAT >= 1) else $error("FETCH_LAT must be at least 1");
      assert (HI_W >= 1) else $error("ADDR_W must exceed page select width");
   end

   assign tag_match   = (tag_q == addr_hi);
   assign start_fetch = !ce_n && rd_act && ((state_q == PG_IDLE) || !tag_match);
   assign cap_en      = !ce_n && !start_fetch && (state_q == PG_FETCH) && (cnt_q == '0);
   assign hit         = pg_valid_q && tag_match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PG_IDLE;
         tag_q      <= '0;
         cnt_q      <= '0;
         pg_valid_q <= 1'b0;
         arr_req    <= 1'b0;
      end else begin
         arr_req <= 1'b0;
         if (ce_n) begin
            state_q    <= PG_IDLE;
            pg_valid_q <= 1'b0;
         end else if (start_fetch) begin
            state_q    <= PG_FETCH;
            tag_q      <= addr_hi;
            cnt_q      <= CNT_LOAD;
            pg_valid_q <= 1'b0;
            arr_req    <= 1'b1;
         end else if (cap_en) begin
            state_q    <= PG_READY;
            pg_valid_q <= 1'b1;
         end else if (state_q == PG_FETCH) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   AST_REQ_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      arr_req |-> $past(rd_act && !ce_n)); // R2
   AST_STANDBY_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> !pg_valid_q); // R4
   AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PG_FETCH && !arr_req) |-> $stable(tag_q)); // R8
   AST_VALID_FROM_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_valid_q) |-> $past(state_q) == PG_FETCH); // R5
endmodule

// File: rtl/pgrd_store.sv
module pgrd_store #(
   parameter int DATA_W     = 16,
   parameter int PAGE_WORDS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cap_en,
   input  logic [PAGE_WORDS*DATA_W-1:0]  arr_rdata,
   input  logic [$clog2(PAGE_WORDS)-1:0] sel,
   output logic [DATA_W-1:0]             word
);
   logic [DATA_W-1:0] words_q [PAGE_WORDS];

   initial begin
      assert (PAGE_WORDS >= 2 && (PAGE_WORDS & (PAGE_WORDS - 1)) == 0)
         else $error("PAGE_WORDS must be a power of two");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      words_q[i] <= '0;
         else if (cap_en) words_q[i] <= arr_rdata[i*DATA_W +: DATA_W];
      end
   end

   assign word = words_q[sel];
endmodule

// File: rtl/pgrd_outmux.sv
module pgrd_outmux #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_act,
   input  logic              hit,
   input  logic [DATA_W-1:0] word_in,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   logic              en_q;
   logic [DATA_W-1:0] q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         q_q  <= '0;
      end else if (rd_act && hit) begin
         en_q <= 1'b1;
         q_q  <= word_in;
      end else begin
         en_q <= 1'b0;
         q_q  <= '0;
      end
   end

   assign dout_en = en_q && rd_act;
   assign dout    = dout_en ? q_q : '0;

   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_act |=> !en_q); // R2
endmodule

// File: rtl/page_read_buffer.sv
module page_read_buffer #(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 20,
   parameter int PAGE_WORDS = 4,
   parameter int FETCH_LAT  = 4
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 ce_n,
   input  logic                                 oe_n,
   input  logic                                 we_n,
   input  logic [ADDR_W-1:0]                    addr,
   output logic                                 arr_req,
   output logic [ADDR_W-$clog2(PAGE_WORDS)-1:0] arr_page,
   input  logic [PAGE_WORDS*DATA_W-1:0]         arr_rdata,
   output logic [DATA_W-1:0]                    dout,
   output logic                                 dout_en
);
   localparam int SEL_W = $clog2(PAGE_WORDS);
   localparam int HI_W  = ADDR_W - SEL_W;

   logic              rd_act;
   logic              cap_en;
   logic              hit;
   logic [DATA_W-1:0] word;
   logic [HI_W-1:0]   addr_hi;
   logic [SEL_W-1:0]  addr_sel;

   assign rd_act   = !ce_n && !oe_n && we_n;
   assign addr_hi  = addr[ADDR_W-1:SEL_W];
   assign addr_sel = addr[SEL_W-1:0];

   pgrd_ctrl #(.ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS), .FETCH_LAT(FETCH_LAT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rd_act(rd_act), .addr_hi(addr_hi),
      .arr_req(arr_req), .tag_q(arr_page), .cap_en(cap_en), .hit(hit)
   );

   pgrd_store #(.DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS)) u_store (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .arr_rdata(arr_rdata),
      .sel(addr_sel), .word(word)
   );

   pgrd_outmux #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .hit(hit), .word_in(word),
      .dout(dout), .dout_en(dout_en)
   );

   AST_OE_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!dout_en && dout == '0)); // R3
   AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      arr_req |=> !dout_en); // R5
endmodule

// File: tb/sim_page_read_buffer.sv
`timescale 1ns/1ps
module sim_page_read_buffer;
   localparam int DW = 16;
   localparam int AW = 6;
   localparam int PW = 4;
   localparam int LAT = 3;
   localparam int HW = AW - 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          arr_req;
   logic [HW-1:0] arr_page;
   logic [PW*DW-1:0] arr_rdata;
   logic [DW-1:0] dout;
   logic          dout_en;
   int checks = 0, fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   page_read_buffer #(.DATA_W(DW), .ADDR_W(AW), .PAGE_WORDS(PW), .FETCH_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
      .arr_req(arr_req), .arr_page(arr_page), .arr_rdata(arr_rdata),
      .dout(dout), .dout_en(dout_en)
   );

   function automatic logic [DW-1:0] exp_word(int page, int off);
      return DW'(page * 97 + off * 13 + 16'h5A00);
   endfunction

   always_comb begin
      for (int i = 0; i < PW; i++) arr_rdata[i*DW +: DW] = exp_word(int'(arr_page), i);
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic c, input logic o, input logic w, input int a);
      ce_n = c; oe_n = o; we_n = w; addr = AW'(a);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic fetch_check(input int page, input int off, input string tag);
      tick();
      chk(arr_req == 1'b1, {tag, " req"}, arr_req, 1);
      chk(int'(arr_page) == page, {tag, " page"}, arr_page, page);
      chk(!dout_en, {tag, " early"}, dout_en, 0);
      for (int k = 1; k <= LAT; k++) begin
         tick();
         chk(!dout_en, {tag, " wait"}, dout_en, 0);
         chk(!arr_req, "R8 single req", arr_req, 0);
         chk(int'(arr_page) == page, "R8 page stable", arr_page, page);
      end
      tick();
      chk(dout_en == 1'b1, {tag, " ready"}, dout_en, 1);
      chk(dout == exp_word(page, off), "R1 word", dout, exp_word(page, off));
   endtask

   initial begin
      @(negedge clk);
      chk(!dout_en && dout == '0 && !arr_req, "R2 reset state", dout_en, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      // R2: write enable low blocks reads and fetches
      drive(0, 0, 0, 8'h15);
      for (int k = 0; k < LAT + 3; k++) begin
         tick();
         chk(!dout_en && !arr_req, "R2 write cycle", dout_en, 0);
      end
      // R5 and R6 sweep over every page and offset
      for (int p = 0; p < (1 << HW); p++) begin
         drive(0, 0, 1, p * 4 + (p % 4));
         fetch_check(p, p % 4, "R5");
         for (int o = 0; o < 4; o++) begin
            int off;
            off = (o * 3 + p) % 4;
            drive(0, 0, 1, p * 4 + off);
            tick();
            chk(dout_en == 1'b1, "R6 en", dout_en, 1);
            chk(dout == exp_word(p, off), "R6 word", dout, exp_word(p, off));
            chk(!arr_req, "R6 no req", arr_req, 0);
         end
      end
      // R3: output enable release and return
      drive(0, 1, 1, 15 * 4 + 2);
      #0.1;
      chk(!dout_en && dout == '0, "R3 same cycle", dout, 0);
      tick();
      chk(!dout_en && dout == '0, "R3 held off", dout, 0);
      drive(0, 0, 1, 15 * 4 + 2);
      tick();
      chk(dout_en && dout == exp_word(15, 2), "R3 return", dout, exp_word(15, 2));
      chk(!arr_req, "R3 no refetch", arr_req, 1'b0);
      // R4: standby invalidates
      drive(1, 0, 1, 15 * 4 + 2);
      #0.1;
      chk(!dout_en, "R4 release", dout_en, 0);
      tick();
      tick();
      chk(!dout_en && !arr_req, "R4 standby", dout_en, 0);
      drive(0, 0, 1, 15 * 4 + 1);
      fetch_check(15, 1, "R4");
      // R7: page change during a fetch
      drive(0, 0, 1, 3 * 4 + 0);
      tick();
      chk(arr_req && int'(arr_page) == 3, "R7 first req", arr_page, 3);
      drive(0, 0, 1, 9 * 4 + 3);
      fetch_check(9, 3, "R7");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule